// File: doc/BRIEF.md
# Two-Window I/O Cycle Sequencer

This block times I/O accesses on the card side of a 16-bit card bus bridge. An upstream decoder says which of two I/O windows an access has hit and raises a request. The sequencer then settles two things: whether the transfer is 8 or 16 bits wide, and how many bus clocks the cycle lasts. It holds its strobe for exactly that many clocks and marks the final clock with a one-clock done pulse.

An 8-bit configuration register holds one 4-bit setting group per window. Each group can fix the width, or tell the block to take the width from the card's 16-bit sense line. Two further bits change the cycle length. One lengthens 16-bit cycles by a wait state. The other shortens 8-bit cycles to the three-clock form.

The base lengths are parameters. Their defaults are 6 clocks for a standard 8-bit cycle and 3 clocks for a shortened 8-bit cycle. A standard 16-bit cycle takes 3 clocks, and a 16-bit cycle with the wait state takes 4.

Top module: `io_cycle_seq`

## Requirements
- R1: The configuration register is 8 bits wide and reads back as 00h after reset. A write stores all eight bits, and the stored value appears on `cfg_rdata` one clock after the write. Window w uses bits [4w+3:4w].
- R2: In a window's group, bit 0 sets the width when bit 1 is 0. A value of 0 gives an 8-bit cycle and `wide`=0. A value of 1 gives a 16-bit cycle and `wide`=1.
- R3: When bit 1 of the group is 1, the width follows `card_is16`, sampled on the clock edge that accepts the request. Bit 0 is then ignored.
- R4: A 16-bit cycle lasts 3 clocks. If bit 3 of the group is set, it lasts 4 clocks. Bit 2 has no effect on a 16-bit cycle.
- R5: An 8-bit cycle lasts 6 clocks. If bit 2 of the group is set, it lasts 3 clocks. Bit 3 has no effect on an 8-bit cycle.
- R6: A request is accepted only on an edge where the block is idle. A request raised and dropped while `busy` is high starts no cycle.
- R7: `wide` stays constant for the whole cycle. Changes on `card_is16` or `win_sel` after the request has been accepted do not alter the cycle.
- R8: A register write made during a cycle leaves that cycle's width and length unchanged. The new value applies from the next accepted request.
- R9: `busy` rises on the clock after the accepting edge and stays high for exactly the computed number of consecutive clocks. `done` is high on only the last of those clocks.
- R10: `win_sel` selects which window's group sets up the accepted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register contents |
| req | input | 1 | Access request, held until accepted |
| win_sel | input | 1 | Index of the window that was hit |
| card_is16 | input | 1 | Card's 16-bit I/O sense line |
| busy | output | 1 | Cycle strobe, high for the length of the cycle |
| done | output | 1 | One-clock pulse on the last busy clock |
| wide | output | 1 | Resolved width of the current cycle, 1 = 16-bit |

## Verification
A faulty cycle counter shows up as soon as the first cycle ends. `busy` falls a clock early or late, or `done` misses the last clock. A fault in the width selection shows up on `wide` from the first busy clock. It also changes the cycle length, so the length check catches the same fault a second time. Two kinds of fault can hide in a single access and only show once the stimulus is mixed. The first is a width or length captured at the wrong time. The second is a request accepted while busy. To expose them, the bench changes the sense line, the window index and the register during cycles, then checks the cycle in progress and the idle clocks after it.

// File: rtl/io_seq_pkg.sv
package io_seq_pkg;
   localparam int GRP_W = 4;

   // Per-window settings, bit 3 down to bit 0.
   typedef struct packed {
      logic ext16;    // bit 3: extra wait state on 16-bit cycles
      logic fast8;    // bit 2: short 8-bit cycle
      logic use_card; // bit 1: width from the card sense line
      logic size16;   // bit 0: fixed width, 1 = 16-bit
   } win_grp_t;
endpackage

// File: rtl/io_cfg_reg.sv
module io_cfg_reg
   import io_seq_pkg::*;
#(
   parameter int NUM_WIN = 2,
   localparam int REG_W = NUM_WIN * GRP_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [REG_W-1:0]        wdata,
   output logic [REG_W-1:0]        rdata,
   output win_grp_t [NUM_WIN-1:0]  grp
);
   logic [REG_W-1:0] reg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_q <= '0;
      else if (we) reg_q <= wdata;
   end

   assign rdata = reg_q;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_grp
      assign grp[w] = win_grp_t'(reg_q[w*GRP_W +: GRP_W]);
   end
endmodule

// File: rtl/io_len_calc.sv
module io_len_calc
   import io_seq_pkg::*;
#(
   parameter int NUM_WIN   = 2,
   parameter int LEN8_STD  = 6,
   parameter int LEN8_FAST = 3,
   parameter int LEN16_STD = 3,
   parameter int WAIT_CLKS = 1,
   parameter int CNT_W     = 3,
   localparam int SEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
   input  win_grp_t [NUM_WIN-1:0]  grp,
   input  logic [SEL_W-1:0]        sel,
   input  logic                    card_is16,
   output logic                    wide,
   output logic [CNT_W-1:0]        len
);
   localparam logic [CNT_W-1:0] L8S  = CNT_W'(LEN8_STD);
   localparam logic [CNT_W-1:0] L8F  = CNT_W'(LEN8_FAST);
   localparam logic [CNT_W-1:0] L16S = CNT_W'(LEN16_STD);
   localparam logic [CNT_W-1:0] L16E = CNT_W'(LEN16_STD + WAIT_CLKS);

   logic [NUM_WIN-1:0] wide_w;
   logic [CNT_W-1:0]   len_w [NUM_WIN];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      always_comb begin
         wide_w[w] = grp[w].use_card ? card_is16 : grp[w].size16;
         if (wide_w[w]) len_w[w] = grp[w].ext16 ? L16E : L16S;
         else           len_w[w] = grp[w].fast8 ? L8F : L8S;
      end
   end

   assign wide = wide_w[sel];
   assign len  = len_w[sel];
endmodule

// File: rtl/io_cycle_fsm.sv
module io_cycle_fsm #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wide_in,
   input  logic [CNT_W-1:0] len_in,
   output logic             busy,
   output logic             done,
   output logic             wide
);
   logic             busy_q;
   logic             wide_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wide_q <= 1'b0;
         left_q <= '0;
      end else if (!busy_q) begin
         if (req) begin
            busy_q <= 1'b1;
            wide_q <= wide_in;
            left_q <= len_in - CNT_W'(1);
         end
      end else if (left_q == '0) begin
         busy_q <= 1'b0;
      end else begin
         left_q <= left_q - CNT_W'(1);
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (left_q == '0);
   assign wide = wide_q;
endmodule

// File: rtl/io_cycle_seq.sv
module io_cycle_seq
   import io_seq_pkg::*;
#(
   parameter int NUM_WIN   = 2,
   parameter int LEN8_STD  = 6,
   parameter int LEN8_FAST = 3,
   parameter int LEN16_STD = 3,
   parameter int WAIT_CLKS = 1,
   localparam int REG_W    = NUM_WIN * GRP_W,
   localparam int SEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int LEN16_EXT = LEN16_STD + WAIT_CLKS,
   localparam int MAX_A    = (LEN8_STD > LEN8_FAST) ? LEN8_STD : LEN8_FAST,
   localparam int MAX_B    = (LEN16_EXT > LEN16_STD) ? LEN16_EXT : LEN16_STD,
   localparam int MAX_LEN  = (MAX_A > MAX_B) ? MAX_A : MAX_B,
   localparam int CNT_W    = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             req,
   input  logic [SEL_W-1:0] win_sel,
   input  logic             card_is16,
   output logic             busy,
   output logic             done,
   output logic             wide
);
   if (NUM_WIN < 2 || (1 << SEL_W) != NUM_WIN) begin : g_bad_win
      $error("NUM_WIN must be a power of two, at least 2");
   end
   if (LEN8_STD < 1 || LEN8_FAST < 1 || LEN16_STD < 1 || WAIT_CLKS < 0) begin : g_bad_len
      $error("cycle lengths must be at least one clock");
   end

   win_grp_t [NUM_WIN-1:0] grp;
   logic                   wide_sel;
   logic [CNT_W-1:0]       len_sel;

   io_cfg_reg #(.NUM_WIN(NUM_WIN)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .grp   (grp)
   );

   io_len_calc #(
      .NUM_WIN   (NUM_WIN),
      .LEN8_STD  (LEN8_STD),
      .LEN8_FAST (LEN8_FAST),
      .LEN16_STD (LEN16_STD),
      .WAIT_CLKS (WAIT_CLKS),
      .CNT_W     (CNT_W)
   ) u_len (
      .grp       (grp),
      .sel       (win_sel),
      .card_is16 (card_is16),
      .wide      (wide_sel),
      .len       (len_sel)
   );

   io_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .wide_in (wide_sel),
      .len_in  (len_sel),
      .busy    (busy),
      .done    (done),
      .wide    (wide)
   );
endmodule

// File: rtl/io_cycle_seq_chk.sv
module io_cycle_seq_chk #(
   parameter int LEN8_STD  = 6,
   parameter int LEN8_FAST = 3,
   parameter int LEN16_STD = 3,
   parameter int WAIT_CLKS = 1
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic wide
);
   int run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy); // R9
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R9
   AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R9
   AST_WIDTH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(wide)); // R7
   AST_LEN16_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && wide) |-> (run_q + 1 == LEN16_STD || run_q + 1 == LEN16_STD + WAIT_CLKS)); // R4
   AST_LEN8_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wide) |-> (run_q + 1 == LEN8_STD || run_q + 1 == LEN8_FAST)); // R5
endmodule

bind io_cycle_seq io_cycle_seq_chk #(
   .LEN8_STD  (LEN8_STD),
   .LEN8_FAST (LEN8_FAST),
   .LEN16_STD (LEN16_STD),
   .WAIT_CLKS (WAIT_CLKS)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .done  (done),
   .wide  (wide)
);

// File: tb/tb_io_cycle_seq.sv
module tb_io_cycle_seq;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       req = 1'b0;
   logic       win_sel = 1'b0;
   logic       card_is16 = 1'b0;
   logic       busy, done, wide;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] cfg_m = '0;

   always #(CLK_P/2) clk = ~clk;

   io_cycle_seq dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req(req), .win_sel(win_sel),
      .card_is16(card_is16), .busy(busy), .done(done), .wide(wide)
   );

   function automatic logic exp_wide(logic [7:0] c, logic w, logic s16);
      logic [3:0] g = w ? c[7:4] : c[3:0];
      return g[1] ? s16 : g[0];
   endfunction

   function automatic int exp_len(logic [7:0] c, logic w, logic s16);
      logic [3:0] g = w ? c[7:4] : c[3:0];
      if (exp_wide(c, w, s16)) return g[3] ? 4 : 3;
      return g[2] ? 3 : 6;
   endfunction

   task automatic check(bit ok, string rq, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic write_cfg(logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_m = v;
      check(cfg_rdata == v, "R1 readback", int'(cfg_rdata), int'(v));
   endtask

   // mode 0: plain; 1: request pulse mid-cycle; 2: register write mid-cycle
   task automatic access(logic w, logic s16, int mode, logic [7:0] newcfg);
      logic ew;
      int   el;
      int   n;
      string wtag, ltag;
      @(negedge clk);
      while (busy) @(negedge clk);
      ew = exp_wide(cfg_m, w, s16);
      el = exp_len(cfg_m, w, s16);
      wtag = (w ? cfg_m[5] : cfg_m[1]) ? "R3 width" : "R2 width";
      ltag = ew ? "R4 length" : "R5 length";
      req = 1'b1; win_sel = w; card_is16 = s16;
      @(negedge clk);
      check(busy == 1'b1, "R9 busy start", int'(busy), 1);
      req = 1'b0; card_is16 = ~s16; win_sel = ~w;
      if (mode == 2) begin cfg_we = 1'b1; cfg_wdata = newcfg; end
      n = 0;
      while (busy && n < 20) begin
         check(wide == ew, wtag, int'(wide), int'(ew));
         check(done == (n == el - 1), "R9 done position", int'(done), int'(n == el - 1));
         if (mode == 1) req = (n == 0);
         if (mode == 2 && n == 0) check(1'b1, "R8 write issued", 0, 0);
         n++;
         @(negedge clk);
         cfg_we = 1'b0;
      end
      check(n == el, mode == 2 ? "R8 length kept" : ltag, n, el);
      if (mode == 2) cfg_m = newcfg;
      if (mode == 1) begin
         req = 1'b0;
         check(busy == 1'b0, "R6 ignored while busy", int'(busy), 0);
         @(negedge clk);
         check(busy == 1'b0, "R6 ignored while busy", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R9 reset busy", int'(busy), 0);
      check(done == 1'b0, "R9 reset done", int'(done), 0);
      check(cfg_rdata == 8'h00, "R1 reset value", int'(cfg_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R5: fixed widths, window 0
      access(1'b0, 1'b1, 0, 8'h00);              // 8-bit std, sense ignored
      write_cfg(8'h01); access(1'b0, 1'b0, 0, 8'h00); // 16-bit std
      // R4 / R5: timing bits and their non-effect
      write_cfg(8'h09); access(1'b0, 1'b0, 0, 8'h00); // 16 ext
      write_cfg(8'h05); access(1'b0, 1'b0, 0, 8'h00); // 16, fast8 no effect
      write_cfg(8'h04); access(1'b0, 1'b1, 0, 8'h00); // 8 fast
      write_cfg(8'h08); access(1'b0, 1'b1, 0, 8'h00); // 8, ext16 no effect
      // R3: width from sense line, size bit ignored
      write_cfg(8'h0A); access(1'b0, 1'b1, 0, 8'h00);
      write_cfg(8'h07); access(1'b0, 1'b0, 0, 8'h00);
      // R10: window selection, groups differ
      write_cfg(8'h90);
      access(1'b1, 1'b0, 0, 8'h00);
      access(1'b0, 1'b0, 0, 8'h00);
      // R6: request pulse mid-cycle
      access(1'b1, 1'b0, 1, 8'h00);
      // R8: write mid-cycle, then new value applies
      access(1'b1, 1'b0, 2, 8'h40);
      access(1'b1, 1'b0, 0, 8'h00);

      for (int i = 0; i < 300; i++) begin
         int m = $urandom_range(0, 5);
         if ($urandom_range(0, 3) == 0) write_cfg(8'($urandom));
         access(1'($urandom), 1'($urandom), (m == 4) ? 1 : (m == 5) ? 2 : 0,
                8'($urandom));
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule